// File: doc/BRIEF.md
# Clustered Thread Rank Generator

This block gives each hardware thread that shares a memory request scheduler a priority rank. It works in fixed-length quanta. On the first clock of each quantum it takes one copy of four per-thread monitor values: miss intensity (misses per kilo-instruction), bandwidth used, a bank-parallelism score and a row-locality score. It also copies a software-set threshold fraction. From that copy it splits the threads into two groups. The light group holds the threads with low memory intensity and is ordered by intensity, so the lighter threads win. The heavy group gets the remaining ranks, and the order inside it is shuffled at regular intervals. The shuffle follows a niceness order: threads with high bank parallelism and low row locality get the top heavy slot more often, and the least nice thread holds it only once per round.

The work runs as a short sequence of phases of N cycles each, so that no wide sort sits on a critical path. The result appears on a rank vector that changes all at once together with a one-cycle valid pulse. The output is a strobe with no ready input and no back-pressure: the scheduler must capture the vector in the cycle the pulse is high, because the block never stalls or queues a result. Quantum length and shuffle interval are parameters and are scaled down for simulation.

Top module: `thread_rank_gen`

## Requirements
- R1: With each pulse, `rank_o` holds a permutation of 0..N-1. Thread i's rank sits in bits [i*RW +: RW], where RW = log2(N), and rank 0 is the highest priority.
- R2: Threads are visited in ascending miss-intensity order, with ties going to the lower thread index. Each visited thread joins the light group while the running bandwidth sum, including that thread, stays at or below floor(thresh_i × total bandwidth / 2^FW). The first thread that does not fit ends the light group, so it and every later thread are heavy, even a later thread with a small bandwidth.
- R3: Every light thread has a smaller rank value than every heavy thread.
- R4: Light threads take ranks 0..L-1 in ascending miss-intensity order, with ties going to the lower thread index. L is the size of the light group.
- R5: For each heavy thread, b is its ascending bank-parallelism position among the heavy threads and r is its ascending row-locality position among the heavy threads, with ties going to the lower index in both. Its niceness key is r − b. The niceness order puts smaller keys first, with ties going to the lower index. Position p = 0 is the nicest thread.
- R6: The heavy threads take ranks L..N-1 as L + q. The value q is worked out from the niceness position p and a schedule pair (w, s). If p < w, then q = (p − s) mod w; otherwise q = p. The schedule starts at (1, 0) in every quantum. Each shuffle step moves s up by one while s+1 < w. Otherwise it sets s to 0 and moves w up by one, wrapping back to 1 once w ≥ H, where H is the number of heavy threads.
- R7: Monitor inputs and thresh_i are used only at the clock edge that starts a quantum. Changes at other times have no effect on any output within that quantum.
- R8: `rank_valid_o` is a one-cycle pulse. The first pulse of a quantum follows 4N+1 clocks after the quantum-start edge, and further pulses follow every SHUFFLE clocks until the next quantum starts. `rank_o` changes only together with a pulse.
- R9: During reset and until the first pulse, `rank_valid_o` is 0 and `rank_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thresh_i | input | FW | Light-group bandwidth budget, as a fraction of total bandwidth in units of 2^-FW |
| mpki_i | input | N*MW | Per-thread miss intensity, thread i in [i*MW +: MW] |
| bw_i | input | N*BWW | Per-thread bandwidth used, thread i in [i*BWW +: BWW] |
| blp_i | input | N*MW | Per-thread bank-parallelism score |
| rbl_i | input | N*MW | Per-thread row-locality score |
| rank_o | output | N*RW | Rank vector, thread i in [i*RW +: RW], 0 = highest priority |
| rank_valid_o | output | 1 | One-cycle pulse marking a new rank vector |

## Verification
The bench runs several directed input patterns. With every bandwidth at zero, all threads fall into the light group, which shows the pure intensity order. With a zero threshold, all threads are heavy, which drives the full shuffle window. Equal intensities and equal parallelism/locality scores expose the lower-index tie rule. A budget that a prefix of threads meets exactly separates an inclusive compare from a strict one. A small-bandwidth thread placed after one that overflows the budget shows whether the walk stops at the first overflow or skips ahead. Random monitor sets follow these directed cases. In every quantum the inputs are scrambled halfway through, so a design that samples them outside the quantum start produces wrong later ranks.

// File: rtl/crg_pkg.sv
package crg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SORT,
    ST_WALK,
    ST_NICE,
    ST_POS,
    ST_PUB
  } crg_state_e;

  // Slot inside the heavy group for niceness position p under window w and offset s.
  function automatic int unsigned heavy_slot(int unsigned p, int unsigned w, int unsigned s);
    if (p < w) begin
      return (p >= s) ? (p - s) : (p + w - s);
    end
    return p;
  endfunction

endpackage

// File: rtl/crg_rank_count.sv
// Counts the masked entries that order ahead of the selected entry
// (smaller value, or equal value with a lower index).
module crg_rank_count #(
  parameter int N = 8,
  parameter int W = 8
) (
  input  logic [N*W-1:0]         vals,
  input  logic [N-1:0]           mask,
  input  logic [$clog2(N)-1:0]   sel,
  output logic [$clog2(N)-1:0]   cnt
);
  localparam int IW = $clog2(N);

  logic [W-1:0] vsel;
  assign vsel = vals[sel*W +: W];

  always_comb begin
    cnt = '0;
    for (int j = 0; j < N; j++) begin
      if (mask[j] && (IW'(j) != sel)) begin
        if ((vals[j*W +: W] < vsel) || ((vals[j*W +: W] == vsel) && (IW'(j) < sel)))
          cnt = cnt + IW'(1);
      end
    end
  end
endmodule

// File: rtl/crg_sched.sv
// Window/offset schedule for the heavy-group shuffle.
module crg_sched #(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   restart,
  input  logic                   advance,
  input  logic [$clog2(N):0]     hcnt,
  output logic [$clog2(N):0]     win,
  output logic [$clog2(N)-1:0]   rot
);
  localparam int IW = $clog2(N);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      win <= (IW+1)'(1);
      rot <= '0;
    end else if (advance) begin
      if (((IW+1)'(rot) + (IW+1)'(1)) < win) begin
        rot <= rot + IW'(1);
      end else begin
        rot <= '0;
        win <= (win >= hcnt) ? (IW+1)'(1) : win + (IW+1)'(1);
      end
    end
  end

  assert_rot_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    (((IW+1)'(rot) < win) && (win != '0)));

endmodule

// File: rtl/thread_rank_gen.sv
module thread_rank_gen
  import crg_pkg::*;
#(
  parameter int N       = 8,
  parameter int MW      = 8,
  parameter int BWW     = 12,
  parameter int FW      = 8,
  parameter int QUANTUM = 512,
  parameter int SHUFFLE = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [FW-1:0]               thresh_i,
  input  logic [N*MW-1:0]             mpki_i,
  input  logic [N*BWW-1:0]            bw_i,
  input  logic [N*MW-1:0]             blp_i,
  input  logic [N*MW-1:0]             rbl_i,
  output logic [N*$clog2(N)-1:0]      rank_o,
  output logic                        rank_valid_o
);
  localparam int IW   = $clog2(N);
  localparam int KW   = IW + 1;
  localparam int SUMW = BWW + IW;
  localparam int PW   = SUMW + FW;
  localparam int QW   = $clog2(QUANTUM);
  localparam int SW   = $clog2(SHUFFLE);

  crg_state_e state;
  logic [QW-1:0]     qcnt;
  logic [SW-1:0]     scnt;
  logic [IW-1:0]     k;
  logic              k_last, q_start, shuf_adv, shuf_pub;

  logic [N*MW-1:0]   s_mpki, s_blp, s_rbl;
  logic [N*BWW-1:0]  s_bw;
  logic [FW-1:0]     s_thr;

  logic [IW-1:0]     mpos [N];
  logic [IW-1:0]     ord_id [N];
  logic [IW-1:0]     npos [N];
  logic [N-1:0]      light;
  logic [IW:0]       lcnt, hcnt;
  logic [SUMW-1:0]   sum_q, total, limit, cand;
  logic              open_q;
  logic [N*KW-1:0]   key;

  logic [IW-1:0]     mcnt, bcnt, rcnt, kcnt;
  logic [IW:0]       win;
  logic [IW-1:0]     rot;
  logic [N*IW-1:0]   compose;

  assign q_start  = (qcnt == '0);
  assign k_last   = (k == IW'(N-1));
  assign hcnt     = (IW+1)'(N) - lcnt;
  assign shuf_adv = (state == ST_IDLE) && (scnt == SW'(SHUFFLE-2)) && !q_start;
  assign shuf_pub = (state == ST_IDLE) && (scnt == SW'(SHUFFLE-1));

  // Budget for the light group from the sampled totals.
  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) total = total + SUMW'(s_bw[i*BWW +: BWW]);
  end
  assign limit = SUMW'((PW'(s_thr) * PW'(total)) >> FW);
  assign cand  = sum_q + SUMW'(s_bw[ord_id[k]*BWW +: BWW]);

  // Shared position counters, one per ordering the phases need.
  crg_rank_count #(.N(N), .W(MW)) u_mpki_pos (
    .vals(s_mpki), .mask({N{1'b1}}), .sel(k), .cnt(mcnt));
  crg_rank_count #(.N(N), .W(MW)) u_blp_pos (
    .vals(s_blp), .mask(~light), .sel(k), .cnt(bcnt));
  crg_rank_count #(.N(N), .W(MW)) u_rbl_pos (
    .vals(s_rbl), .mask(~light), .sel(k), .cnt(rcnt));
  crg_rank_count #(.N(N), .W(KW)) u_nice_pos (
    .vals(key), .mask(~light), .sel(k), .cnt(kcnt));

  crg_sched #(.N(N)) u_sched (
    .clk(clk), .rst(rst), .restart(q_start), .advance(shuf_adv),
    .hcnt(hcnt), .win(win), .rot(rot));

  // Rank vector from the cluster split, the niceness order and the schedule.
  always_comb begin
    compose = '0;
    for (int i = 0; i < N; i++) begin
      if (light[i]) begin
        compose[i*IW +: IW] = mpos[i];
      end else begin
        compose[i*IW +: IW] = IW'(lcnt) +
          IW'(heavy_slot(int'(npos[i]), int'(win), int'(rot)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      qcnt         <= '0;
      scnt         <= '0;
      k            <= '0;
      s_mpki       <= '0;
      s_blp        <= '0;
      s_rbl        <= '0;
      s_bw         <= '0;
      s_thr        <= '0;
      light        <= '0;
      lcnt         <= '0;
      sum_q        <= '0;
      open_q       <= 1'b0;
      key          <= '0;
      rank_o       <= '0;
      rank_valid_o <= 1'b0;
      for (int i = 0; i < N; i++) begin
        mpos[i]   <= '0;
        ord_id[i] <= '0;
        npos[i]   <= '0;
      end
    end else begin
      rank_valid_o <= 1'b0;
      qcnt <= (qcnt == QW'(QUANTUM-1)) ? '0 : qcnt + QW'(1);
      if (q_start) begin
        s_mpki <= mpki_i;
        s_blp  <= blp_i;
        s_rbl  <= rbl_i;
        s_bw   <= bw_i;
        s_thr  <= thresh_i;
        light  <= '0;
        lcnt   <= '0;
        sum_q  <= '0;
        open_q <= 1'b1;
        k      <= '0;
        state  <= ST_SORT;
      end else begin
        case (state)
          ST_SORT: begin
            mpos[k]      <= mcnt;
            ord_id[mcnt] <= k;
            k <= k_last ? '0 : k + IW'(1);
            if (k_last) state <= ST_WALK;
          end
          ST_WALK: begin
            if (open_q && (cand <= limit)) begin
              light[ord_id[k]] <= 1'b1;
              sum_q <= cand;
              lcnt  <= lcnt + (IW+1)'(1);
            end else begin
              open_q <= 1'b0;
            end
            k <= k_last ? '0 : k + IW'(1);
            if (k_last) state <= ST_NICE;
          end
          ST_NICE: begin
            key[k*KW +: KW] <= light[k] ? '0 : (KW'(N) + KW'(rcnt) - KW'(bcnt));
            k <= k_last ? '0 : k + IW'(1);
            if (k_last) state <= ST_POS;
          end
          ST_POS: begin
            npos[k] <= kcnt;
            k <= k_last ? '0 : k + IW'(1);
            if (k_last) state <= ST_PUB;
          end
          ST_PUB: begin
            rank_o       <= compose;
            rank_valid_o <= 1'b1;
            scnt         <= '0;
            state        <= ST_IDLE;
          end
          default: begin
            if (shuf_pub) begin
              rank_o       <= compose;
              rank_valid_o <= 1'b1;
              scnt         <= '0;
            end else begin
              scnt <= scnt + SW'(1);
            end
          end
        endcase
      end
    end
  end

  // ---------------- assertions ----------------
  logic [N-1:0] rank_hits;
  logic         light_first_ok;
  always_comb begin
    rank_hits      = '0;
    light_first_ok = 1'b1;
    for (int i = 0; i < N; i++) begin
      rank_hits[rank_o[i*IW +: IW]] = 1'b1;
      if (light[i] && ((IW+1)'(rank_o[i*IW +: IW]) >= lcnt)) light_first_ok = 1'b0;
      if (!light[i] && ((IW+1)'(rank_o[i*IW +: IW]) < lcnt)) light_first_ok = 1'b0;
    end
  end

  assert_rank_perm_R1: assert property (@(posedge clk) disable iff (rst)
    rank_valid_o |-> (&rank_hits));

  assert_light_first_R3: assert property (@(posedge clk) disable iff (rst)
    rank_valid_o |-> light_first_ok);

  assert_budget_R2: assert property (@(posedge clk) disable iff (rst)
    sum_q <= limit);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rank_valid_o |=> !rank_valid_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rank_valid_o |-> $stable(rank_o));

endmodule

// File: tb/thread_rank_gen_test.sv
`timescale 1ns/1ps
module thread_rank_gen_test;
  localparam int N   = 8;
  localparam int MW  = 8;
  localparam int BWW = 12;
  localparam int FW  = 8;
  localparam int Q   = 512;
  localparam int S   = 64;
  localparam int IW  = 3;
  localparam int NQ  = 12;
  localparam int LAT = 4*N + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [FW-1:0]    thresh_i = '0;
  logic [N*MW-1:0]  mpki_i = '0, blp_i = '0, rbl_i = '0;
  logic [N*BWW-1:0] bw_i = '0;
  logic [N*IW-1:0]  rank_o;
  logic             rank_valid_o;

  always #4 clk = ~clk;

  thread_rank_gen #(.N(N), .MW(MW), .BWW(BWW), .FW(FW), .QUANTUM(Q), .SHUFFLE(S)) uut (
    .clk(clk), .rst(rst), .thresh_i(thresh_i), .mpki_i(mpki_i), .bw_i(bw_i),
    .blp_i(blp_i), .rbl_i(rbl_i), .rank_o(rank_o), .rank_valid_o(rank_valid_o));

  int checks = 0, errors = 0;
  int tm [NQ+1][N], tb [NQ+1][N], tp [NQ+1][N], tr [NQ+1][N], tt [NQ+1];
  int pcnt [NQ];
  int cyc = 0, lastoff = 0;
  bit done = 0, prev_valid = 0;
  logic [N*IW-1:0] last_rank = '0;
  logic [N*IW-1:0] e_rank;
  bit e_light [N];
  int e_lc;

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model built from the requirements.
  task automatic model(int q, int step);
    int ord [N]; int pos [N]; bit used [N];
    int br [N], rr [N], key [N], np [N];
    int total, lim, sum, h, w, s, best, pp, rk;
    bit open_w;
    for (int i = 0; i < N; i++) used[i] = 0;
    for (int p = 0; p < N; p++) begin
      best = -1;
      for (int j = 0; j < N; j++)
        if (!used[j] && (best < 0 || tm[q][j] < tm[q][best])) best = j;
      ord[p] = best; used[best] = 1; pos[best] = p;
    end
    total = 0;
    for (int i = 0; i < N; i++) total += tb[q][i];
    lim = (tt[q] * total) / 256;
    sum = 0; open_w = 1; e_lc = 0;
    for (int i = 0; i < N; i++) e_light[i] = 0;
    for (int p = 0; p < N; p++) begin
      if (open_w && (sum + tb[q][ord[p]] <= lim)) begin
        sum += tb[q][ord[p]]; e_light[ord[p]] = 1; e_lc++;
      end else open_w = 0;
    end
    for (int i = 0; i < N; i++) begin
      br[i] = 0; rr[i] = 0;
      for (int j = 0; j < N; j++) begin
        if (!e_light[i] && !e_light[j] && j != i) begin
          if (tp[q][j] < tp[q][i] || (tp[q][j] == tp[q][i] && j < i)) br[i]++;
          if (tr[q][j] < tr[q][i] || (tr[q][j] == tr[q][i] && j < i)) rr[i]++;
        end
      end
      key[i] = rr[i] - br[i];
    end
    for (int i = 0; i < N; i++) begin
      np[i] = 0;
      for (int j = 0; j < N; j++)
        if (!e_light[i] && !e_light[j] && j != i &&
            (key[j] < key[i] || (key[j] == key[i] && j < i))) np[i]++;
    end
    h = N - e_lc; w = 1; s = 0;
    for (int t = 0; t < step; t++) begin
      if (s + 1 < w) s++;
      else begin s = 0; w = (w >= h) ? 1 : w + 1; end
    end
    for (int i = 0; i < N; i++) begin
      if (e_light[i]) rk = pos[i];
      else begin
        pp = np[i];
        rk = e_lc + ((pp < w) ? ((pp >= s) ? pp - s : pp + w - s) : pp);
      end
      e_rank[i*IW +: IW] = rk[IW-1:0];
    end
  endtask

  task automatic apply(int q);
    for (int i = 0; i < N; i++) begin
      mpki_i[i*MW +: MW]  = tm[q][i][MW-1:0];
      bw_i[i*BWW +: BWW]  = tb[q][i][BWW-1:0];
      blp_i[i*MW +: MW]   = tp[q][i][MW-1:0];
      rbl_i[i*MW +: MW]   = tr[q][i][MW-1:0];
    end
    thresh_i = tt[q][FW-1:0];
  endtask

  task automatic apply_junk();
    mpki_i   = {$urandom, $urandom};
    blp_i    = {$urandom, $urandom};
    rbl_i    = {$urandom, $urandom};
    bw_i     = {$urandom, $urandom, $urandom};
    thresh_i = FW'($urandom);
  endtask

  // Pulse checker.
  always @(negedge clk) begin
    int qi, off, step;
    bit perm_ok, lf_ok;
    logic [N-1:0] seen;
    if (!rst && !done) begin
      if (rank_valid_o) begin
        chk(!prev_valid, "R8 pulse width", 64'(prev_valid), 64'd0);
        qi  = (cyc - 1) / Q;
        off = (cyc - 1) % Q;
        if (qi < NQ) begin
          step = pcnt[qi];
          if (step == 0) chk(off == LAT, "R8 first pulse offset", 64'(off), 64'(LAT));
          else           chk(off - lastoff == S, "R8 shuffle spacing", 64'(off - lastoff), 64'(S));
          lastoff = off;
          model(qi, step);
          seen = '0;
          for (int i = 0; i < N; i++) seen[rank_o[i*IW +: IW]] = 1'b1;
          perm_ok = &seen;
          chk(perm_ok, "R1 permutation", 64'(seen), 64'hff);
          lf_ok = 1;
          for (int i = 0; i < N; i++) begin
            if (e_light[i] && int'(rank_o[i*IW +: IW]) >= e_lc) lf_ok = 0;
            if (!e_light[i] && int'(rank_o[i*IW +: IW]) < e_lc) lf_ok = 0;
          end
          chk(lf_ok, "R3 light above heavy", 64'(rank_o), 64'(e_rank));
          if (off > 200)
            chk(rank_o == e_rank, "R7 R2 R4 R5 R6 ranks after mid-quantum input change",
                64'(rank_o), 64'(e_rank));
          else
            chk(rank_o == e_rank, "R2 R4 R5 R6 ranks", 64'(rank_o), 64'(e_rank));
          pcnt[qi]++;
        end
        last_rank = rank_o;
      end else begin
        chk(rank_o == last_rank, "R8 hold between pulses", 64'(rank_o), 64'(last_rank));
      end
      prev_valid = rank_valid_o;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int q = 0; q < NQ; q++) pcnt[q] = 0;
    for (int q = 0; q <= NQ; q++) begin
      tt[q] = $urandom % 256;
      for (int i = 0; i < N; i++) begin
        tm[q][i] = $urandom % 64;
        tb[q][i] = $urandom % 256;
        tp[q][i] = $urandom % 16;
        tr[q][i] = $urandom % 16;
      end
    end
    // q0: no bandwidth used, everything light (R4 ordering)
    tt[0] = 255;
    for (int i = 0; i < N; i++) begin tm[0][i] = (i * 37 + 11) % 64; tb[0][i] = 0; end
    // q1: zero threshold, everything heavy (R5 R6 full window)
    tt[1] = 0;
    for (int i = 0; i < N; i++) tb[1][i] = 10;
    // q2: equal intensities, ties by index
    tt[2] = 128;
    for (int i = 0; i < N; i++) begin tm[2][i] = 5; tb[2][i] = 20 + i; end
    // q3: prefix meets the budget exactly (inclusive compare, R2)
    tt[3] = 64;
    for (int i = 0; i < N; i++) begin tm[3][i] = 50 - i; tb[3][i] = 32; end
    // q4: equal parallelism and locality scores, all heavy
    tt[4] = 0;
    for (int i = 0; i < N; i++) begin tp[4][i] = 3; tr[4][i] = 7; end
    // q5: walk stops at first overflow although a later thread is small (R2)
    tt[5] = 128;
    for (int i = 0; i < N; i++) begin tm[5][i] = i * 10; tb[5][i] = 10; end
    tb[5][0] = 100; tb[5][1] = 200; tb[5][2] = 1;

    apply(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rank_valid_o == 1'b0 && rank_o == '0, "R9 reset state", 64'(rank_o), 64'd0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(rank_valid_o == 1'b0 && rank_o == '0, "R9 before first pulse", 64'(rank_o), 64'd0);
    @(posedge clk); #1;
    // Align: 11 edges consumed after release so far.
    for (int q = 0; q < NQ; q++) begin
      if (q == 0) repeat (200 - 11) @(posedge clk);
      else        repeat (200) @(posedge clk);
      #1 apply_junk();
      repeat (Q - 216) @(posedge clk);
      #1 apply(q + 1);
      repeat (16) @(posedge clk);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1;
    for (int q = 0; q < NQ; q++)
      chk(pcnt[q] == Q / S, "R8 pulses per quantum", 64'(pcnt[q]), 64'(Q / S));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule